// File: doc/BRIEF.md
# T1 Loopback Path and In-Band Loop Code Controller

This block picks the loopback path of a T1 line interface. A host writes three control bits: transmit all ones, local loopback and remote loopback. From these bits and a latched automatic-loopback state, the block steers two outputs. The transmit line output gets the transmit data, an all-ones request, or the recovered receive data. The receive-side outputs get either the recovered line signal or a copy of the transmit signal. A write that asks for local and remote loopback at the same time, with all-ones off, raises a one-cycle reset request.

A detector for in-band loop codes runs in the background. It is armed by two writes in sequence: first all three control bits set, then all three cleared on the very next write. Once armed, every received bit (marked by a bit strobe) is checked against two repeating codes. The enable code has a period of five bits with a single one. The disable code has a period of three bits with a single one. A code that persists for a qualification period, counted in received bits, latches or clears automatic remote loopback. A limited number of code mismatches per window of received bits is tolerated. Local loopback holds the automatic state suspended, and remote loopback from the host cancels it.

Top module: `t1_loopback_ctrl`

## Requirements
- R1: While the stored local-loopback bit is 1, `rcv_sel` is 1 and `rcv_clk`/`rcv_data` follow `tx_clk`/`tx_data`. Otherwise `rcv_sel` is 0 and they follow `rx_clk`/`rx_data`.
- R2: When remote loopback is not in effect, `line_tx_sel` is 0 with `line_tx_clk`/`line_tx_data` equal to `tx_clk`/`tx_data`. If the stored all-ones bit is 1 instead, `line_tx_sel` is 1, `line_tx_data` is 1 and `line_tx_clk` is `tx_clk`. This holds whether or not local loopback is on.
- R3: Remote loopback is in effect when the stored remote bit is 1 or automatic loopback is active. It makes `line_tx_sel` 2 and `line_tx_clk`/`line_tx_data` equal `rx_clk`/`rx_data`, whatever the all-ones bit is.
- R4: `reset_req` is 1 for exactly the cycle after a write with local=1, remote=1 and all-ones=0. It is 0 after any other write.
- R5: `nl_armed` becomes 1 in the cycle after a write of all-zero control bits, provided the write just before it set all three bits. Any other write in between cancels the sequence.
- R6: `nl_armed` is 0 after reset. It returns to 0 in the cycle after the stored remote bit is seen at 1, unless that same cycle carries an arming write.
- R7: A received bit is taken only when `rx_bit_en`, `nl_armed` and not local loopback all hold. The enable code matches when the newest 5 taken bits contain exactly one 1. The disable code matches when the newest 3 taken bits contain exactly one 1. The bit history reads as zeros while disarmed.
- R8: After QUAL_BITS taken bits with no restart, the enable code qualifies and `nl_active` rises in the next cycle. Remote loopback then takes effect exactly as in R3.
- R9: Disable-code qualification, a stored remote bit of 1, or disarming clears the automatic state in the next cycle. A clear wins over an enable qualification in the same cycle.
- R10: While local loopback is on, `nl_active` reads 0 and received bits are ignored. The latched automatic state is kept, and `nl_active` returns when local loopback is released.
- R11: Each code counts mismatches within windows of WIN_BITS taken bits, and the count clears when a window closes. A mismatch that arrives when ERR_MAX mismatches are already counted restarts that code's persistence timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_taos | input | 1 | Written all-ones request bit |
| cfg_lloop | input | 1 | Written local loopback bit |
| cfg_rloop | input | 1 | Written remote loopback bit |
| tx_clk | input | 1 | Transmit clock from the system side |
| tx_data | input | 1 | Transmit data from the system side |
| rx_clk | input | 1 | Recovered line clock |
| rx_data | input | 1 | Recovered line data |
| rx_bit_en | input | 1 | One-cycle strobe marking a new recovered bit |
| line_tx_sel | output | 2 | Line transmit source: 0 system data, 1 all ones, 2 recovered |
| line_tx_clk | output | 1 | Clock toward the line transmitter |
| line_tx_data | output | 1 | Data toward the line transmitter |
| rcv_sel | output | 1 | Receive output source: 0 line, 1 transmit loop |
| rcv_clk | output | 1 | Receive-side clock output |
| rcv_data | output | 1 | Receive-side data output |
| reset_req | output | 1 | One-cycle device reset request |
| nl_armed | output | 1 | Loop code detection armed |
| nl_active | output | 1 | Automatic remote loopback in effect |

## Verification
The enable code can qualify on the very bit cycle in which the host writes the remote-loopback bit. In that cycle one side tries to set the automatic latch while the other is about to clear both it and the armed flag. The bench provokes this by watching its reference model's persistence count. When that count sits one bit short of qualification, the bench delivers the qualifying bit and the remote write on the same clock. It then judges the result cycle by cycle against the model and finally expects both `nl_active` and `nl_armed` at 0 with the line still on the recovered path.

// File: rtl/t1lb_pkg.sv
package t1lb_pkg;

  typedef enum logic [1:0] {
    TXS_PASS  = 2'd0,
    TXS_ONES  = 2'd1,
    TXS_RECOV = 2'd2
  } tx_sel_e;

  localparam logic [2:0] ARM_SET = 3'b111;
  localparam logic [2:0] ARM_CLR = 3'b000;

  // True when exactly one of the lowest len bits of win is set.
  function automatic logic single_one(input logic [7:0] win, input int unsigned len);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < 8; i++) begin
      if (i < len && win[i]) n++;
    end
    return (n == 1);
  endfunction

endpackage

// File: rtl/t1lb_ctl_reg.sv
module t1lb_ctl_reg
  import t1lb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wr_taos,
  input  logic wr_lloop,
  input  logic wr_rloop,
  output logic cr_taos,
  output logic cr_lloop,
  output logic cr_rloop,
  output logic armed,
  output logic arm_evt,
  output logic reset_req
);

  logic [2:0] wr_code;
  logic       seen_set_q;

  assign wr_code = {wr_taos, wr_lloop, wr_rloop};
  assign arm_evt = we && seen_set_q && (wr_code == ARM_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_taos    <= 1'b0;
      cr_lloop   <= 1'b0;
      cr_rloop   <= 1'b0;
      seen_set_q <= 1'b0;
      armed      <= 1'b0;
      reset_req  <= 1'b0;
    end else begin
      reset_req <= we && wr_lloop && wr_rloop && !wr_taos;
      if (we) begin
        cr_taos    <= wr_taos;
        cr_lloop   <= wr_lloop;
        cr_rloop   <= wr_rloop;
        seen_set_q <= (wr_code == ARM_SET);
      end
      if (arm_evt) armed <= 1'b1;
      else if (cr_rloop) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/t1lb_code_watch.sv
module t1lb_code_watch
  import t1lb_pkg::*;
#(
  parameter int unsigned EN_LEN  = 5,
  parameter int unsigned DIS_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic bit_in,
  output logic en_match,
  output logic dis_match
);

  localparam int unsigned HW = EN_LEN - 1;

  logic [HW-1:0]     hist_q;
  logic [EN_LEN-1:0] win;
  logic [7:0]        win8;

  // win[0] is the newest bit
  assign win       = {hist_q, bit_in};
  assign win8      = 8'(win);
  assign en_match  = single_one(win8, EN_LEN);
  assign dis_match = single_one(win8, DIS_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist_q <= '0;
    else if (clear) hist_q <= '0;
    else if (take)  hist_q <= win[HW-1:0];
  end

endmodule

// File: rtl/t1lb_persist.sv
module t1lb_persist #(
  parameter int unsigned QUAL_BITS = 7_720_000,
  parameter int unsigned WIN_BITS  = 1000,
  parameter int unsigned ERR_MAX   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic match,
  output logic restart,
  output logic qual
);

  localparam int unsigned RW = $clog2(QUAL_BITS + 1);
  localparam int unsigned WW = $clog2(WIN_BITS + 1);
  localparam int unsigned EW = $clog2(ERR_MAX + 2);
  localparam logic [RW-1:0] RUN_LAST = RW'(QUAL_BITS - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_BITS - 1);
  localparam logic [EW-1:0] ERR_LIM  = EW'(ERR_MAX);

  logic [RW-1:0] run_q;
  logic [WW-1:0] win_q;
  logic [EW-1:0] err_q;
  logic          last_bit;

  assign last_bit = (run_q == RUN_LAST);
  assign restart  = take && !match && (err_q == ERR_LIM);
  assign qual     = take && !restart && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      win_q <= '0;
      err_q <= '0;
    end else if (clear || (take && (restart || last_bit))) begin
      run_q <= '0;
      win_q <= '0;
      err_q <= '0;
    end else if (take) begin
      run_q <= run_q + 1'b1;
      if (win_q == WIN_LAST) begin
        win_q <= '0;
        err_q <= '0;
      end else begin
        win_q <= win_q + 1'b1;
        err_q <= err_q + {{(EW-1){1'b0}}, ~match};
      end
    end
  end

endmodule

// File: rtl/t1lb_path_sel.sv
module t1lb_path_sel
  import t1lb_pkg::*;
(
  input  logic       cr_taos,
  input  logic       cr_lloop,
  input  logic       remote,
  input  logic       tx_clk,
  input  logic       tx_data,
  input  logic       rx_clk,
  input  logic       rx_data,
  output logic [1:0] line_tx_sel,
  output logic       line_tx_clk,
  output logic       line_tx_data,
  output logic       rcv_sel,
  output logic       rcv_clk,
  output logic       rcv_data
);

  tx_sel_e sel;

  always_comb begin
    if (remote)       sel = TXS_RECOV;
    else if (cr_taos) sel = TXS_ONES;
    else              sel = TXS_PASS;
  end

  always_comb begin
    unique case (sel)
      TXS_RECOV: begin line_tx_clk = rx_clk; line_tx_data = rx_data; end
      TXS_ONES:  begin line_tx_clk = tx_clk; line_tx_data = 1'b1;    end
      default:   begin line_tx_clk = tx_clk; line_tx_data = tx_data; end
    endcase
  end

  assign line_tx_sel = sel;
  assign rcv_sel     = cr_lloop;
  assign rcv_clk     = cr_lloop ? tx_clk  : rx_clk;
  assign rcv_data    = cr_lloop ? tx_data : rx_data;

endmodule

// File: rtl/t1_loopback_ctrl.sv
module t1_loopback_ctrl
  import t1lb_pkg::*;
#(
  parameter int unsigned QUAL_BITS = 7_720_000,
  parameter int unsigned WIN_BITS  = 1000,
  parameter int unsigned ERR_MAX   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_taos,
  input  logic       cfg_lloop,
  input  logic       cfg_rloop,
  input  logic       tx_clk,
  input  logic       tx_data,
  input  logic       rx_clk,
  input  logic       rx_data,
  input  logic       rx_bit_en,
  output logic [1:0] line_tx_sel,
  output logic       line_tx_clk,
  output logic       line_tx_data,
  output logic       rcv_sel,
  output logic       rcv_clk,
  output logic       rcv_data,
  output logic       reset_req,
  output logic       nl_armed,
  output logic       nl_active
);

  localparam int unsigned N_CODES = 2;

  logic cr_taos, cr_lloop, cr_rloop;
  logic armed, arm_evt;
  logic bit_take, remote, auto_q;
  logic en_match, dis_match, en_qual, dis_qual;
  logic [N_CODES-1:0] code_match, code_qual, code_restart;

  t1lb_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wr_taos   (cfg_taos),
    .wr_lloop  (cfg_lloop),
    .wr_rloop  (cfg_rloop),
    .cr_taos   (cr_taos),
    .cr_lloop  (cr_lloop),
    .cr_rloop  (cr_rloop),
    .armed     (armed),
    .arm_evt   (arm_evt),
    .reset_req (reset_req)
  );

  assign bit_take = rx_bit_en && armed && !cr_lloop;

  t1lb_code_watch #(.EN_LEN(5), .DIS_LEN(3)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!armed),
    .take      (bit_take),
    .bit_in    (rx_data),
    .en_match  (en_match),
    .dis_match (dis_match)
  );

  assign code_match = {dis_match, en_match};

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    t1lb_persist #(
      .QUAL_BITS (QUAL_BITS),
      .WIN_BITS  (WIN_BITS),
      .ERR_MAX   (ERR_MAX)
    ) u_persist (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!armed),
      .take    (bit_take),
      .match   (code_match[g]),
      .restart (code_restart[g]),
      .qual    (code_qual[g])
    );
  end

  assign en_qual  = code_qual[0];
  assign dis_qual = code_qual[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             auto_q <= 1'b0;
    else if (!armed || cr_rloop || dis_qual) auto_q <= 1'b0;
    else if (en_qual)                       auto_q <= 1'b1;
  end

  assign nl_active = auto_q && !cr_lloop;
  assign nl_armed  = armed;
  assign remote    = cr_rloop || nl_active;

  t1lb_path_sel u_path (
    .cr_taos      (cr_taos),
    .cr_lloop     (cr_lloop),
    .remote       (remote),
    .tx_clk       (tx_clk),
    .tx_data      (tx_data),
    .rx_clk       (rx_clk),
    .rx_data      (rx_data),
    .line_tx_sel  (line_tx_sel),
    .line_tx_clk  (line_tx_clk),
    .line_tx_data (line_tx_data),
    .rcv_sel      (rcv_sel),
    .rcv_clk      (rcv_clk),
    .rcv_data     (rcv_data)
  );

endmodule

// File: rtl/t1lb_checker.sv
module t1lb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       cfg_taos,
  input logic       cfg_lloop,
  input logic       cfg_rloop,
  input logic       cr_lloop,
  input logic       cr_rloop,
  input logic       tx_data,
  input logic       rcv_data,
  input logic [1:0] line_tx_sel,
  input logic       reset_req,
  input logic       armed,
  input logic       arm_evt,
  input logic       auto_q,
  input logic       nl_active,
  input logic       en_qual,
  input logic       dis_qual
);

  assert_local_rcv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cr_lloop |-> (rcv_data == tx_data));

  assert_remote_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cr_rloop |-> (line_tx_sel == 2'd2));

  assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_lloop && cfg_rloop && !cfg_taos) |=> reset_req);

  assert_reset_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(cfg_we));

  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rloop && !arm_evt) |=> !armed);

  assert_qual_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_qual || dis_qual) |-> (armed && !cr_lloop));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_qual || cr_rloop || !armed) |=> !auto_q);

  assert_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cr_lloop |-> !nl_active);

endmodule

bind t1_loopback_ctrl t1lb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_taos    (cfg_taos),
  .cfg_lloop   (cfg_lloop),
  .cfg_rloop   (cfg_rloop),
  .cr_lloop    (cr_lloop),
  .cr_rloop    (cr_rloop),
  .tx_data     (tx_data),
  .rcv_data    (rcv_data),
  .line_tx_sel (line_tx_sel),
  .reset_req   (reset_req),
  .armed       (armed),
  .arm_evt     (arm_evt),
  .auto_q      (auto_q),
  .nl_active   (nl_active),
  .en_qual     (en_qual),
  .dis_qual    (dis_qual)
);

// File: tb/t1_loopback_ctrl_bench.sv
module t1_loopback_ctrl_bench;

  localparam int QB = 120;
  localparam int WB = 50;
  localparam int EM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_taos = 1'b0, cfg_lloop = 1'b0, cfg_rloop = 1'b0;
  logic tx_clk = 1'b0, tx_data = 1'b0, rx_clk = 1'b0, rx_data = 1'b0, rx_bit_en = 1'b0;
  logic [1:0] line_tx_sel;
  logic line_tx_clk, line_tx_data, rcv_sel, rcv_clk, rcv_data;
  logic reset_req, nl_armed, nl_active;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  t1_loopback_ctrl #(.QUAL_BITS(QB), .WIN_BITS(WB), .ERR_MAX(EM)) u_t1_loopback_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_taos(cfg_taos),
    .cfg_lloop(cfg_lloop), .cfg_rloop(cfg_rloop), .tx_clk(tx_clk),
    .tx_data(tx_data), .rx_clk(rx_clk), .rx_data(rx_data), .rx_bit_en(rx_bit_en),
    .line_tx_sel(line_tx_sel), .line_tx_clk(line_tx_clk), .line_tx_data(line_tx_data),
    .rcv_sel(rcv_sel), .rcv_clk(rcv_clk), .rcv_data(rcv_data),
    .reset_req(reset_req), .nl_armed(nl_armed), .nl_active(nl_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_taos, m_ll, m_rl, m_seen, m_armed, m_rst, m_auto;
  int m_run[2], m_win[2], m_err[2];
  bit hq[$] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_taos = 0; m_ll = 0; m_rl = 0; m_seen = 0; m_armed = 0; m_rst = 0; m_auto = 0;
      for (int k = 0; k < 2; k++) begin m_run[k] = 0; m_win[k] = 0; m_err[k] = 0; end
      hq = '{0, 0, 0, 0};
    end else begin
      int take, ones5, ones3, arm;
      int mt[2];
      int q[2];
      take = (rx_bit_en && m_armed && !m_ll) ? 1 : 0;
      ones5 = rx_data; ones3 = rx_data;
      for (int j = 0; j < 4; j++) begin
        ones5 += hq[j];
        if (j >= 2) ones3 += hq[j];
      end
      mt[0] = (ones5 == 1); mt[1] = (ones3 == 1);
      for (int k = 0; k < 2; k++) begin
        q[k] = 0;
        if (!m_armed) begin
          m_run[k] = 0; m_win[k] = 0; m_err[k] = 0;
        end else if (take) begin
          if (!mt[k] && m_err[k] == EM) begin
            m_run[k] = 0; m_win[k] = 0; m_err[k] = 0;
          end else if (m_run[k] == QB - 1) begin
            q[k] = 1; m_run[k] = 0; m_win[k] = 0; m_err[k] = 0;
          end else begin
            m_run[k]++;
            if (m_win[k] == WB - 1) begin m_win[k] = 0; m_err[k] = 0; end
            else begin m_win[k]++; if (!mt[k]) m_err[k]++; end
          end
        end
      end
      if (!m_armed) hq = '{0, 0, 0, 0};
      else if (take) begin void'(hq.pop_front()); hq.push_back(rx_data); end
      if (!m_armed || m_rl || q[1]) m_auto = 0;
      else if (q[0]) m_auto = 1;
      arm = (cfg_we && m_seen && !cfg_taos && !cfg_lloop && !cfg_rloop) ? 1 : 0;
      m_rst = (cfg_we && cfg_lloop && cfg_rloop && !cfg_taos) ? 1 : 0;
      if (arm) m_armed = 1;
      else if (m_rl) m_armed = 0;
      if (cfg_we) begin
        m_seen = (cfg_taos && cfg_lloop && cfg_rloop) ? 1 : 0;
        m_taos = cfg_taos; m_ll = cfg_lloop; m_rl = cfg_rloop;
      end
    end
  end

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int ae, rem, esel, ec, ed;
      ae  = (m_auto && !m_ll) ? 1 : 0;
      rem = (m_rl || ae) ? 1 : 0;
      esel = rem ? 2 : (m_taos ? 1 : 0);
      ec = rem ? rx_clk : tx_clk;
      ed = rem ? rx_data : (m_taos ? 1 : tx_data);
      chk(rem ? "R3 line sel" : "R2 line sel", line_tx_sel, esel);
      chk(rem ? "R3 line clk" : "R2 line clk", line_tx_clk, ec);
      chk(rem ? "R3 line data" : "R2 line data", line_tx_data, ed);
      chk("R1 rcv sel", rcv_sel, m_ll);
      chk("R1 rcv clk", rcv_clk, m_ll ? tx_clk : rx_clk);
      chk("R1 rcv data", rcv_data, m_ll ? tx_data : rx_data);
      chk("R4 reset req", reset_req, m_rst);
      chk("R5 armed", nl_armed, m_armed);
      chk("R8 active", nl_active, ae);
    end
  end

  // background system-side and recovered clock/data activity
  always @(negedge clk) begin
    tx_clk  = 1'($urandom);
    tx_data = 1'($urandom);
    rx_clk  = 1'($urandom);
  end

  // ---------------- stimulus ----------------
  task automatic wr(input bit t, input bit l, input bit r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_taos = t; cfg_lloop = l; cfg_rloop = r;
    @(negedge clk);
    cfg_we = 1'b0;
    #3;
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    rx_bit_en = 1'b1; rx_data = b;
    @(negedge clk);
    rx_bit_en = 1'b0;
  endtask

  task automatic stream(input int period, input int from, input int upto);
    for (int i = from; i <= upto; i++) send_bit((i % period) == 0);
  endtask

  task automatic settle();
    @(negedge clk);
    #3;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R6 reset armed", nl_armed, 0);
    chk("R2 reset sel", line_tx_sel, 0);
    chk("R1 reset rcv sel", rcv_sel, 0);
    chk("R4 reset req idle", reset_req, 0);

    wr(1, 0, 0);
    chk("R2 all-ones sel", line_tx_sel, 1);
    chk("R2 all-ones data", line_tx_data, 1);
    wr(0, 1, 0);
    chk("R1 local rcv data", rcv_data, tx_data);
    chk("R2 local still sends tx", line_tx_data, tx_data);
    wr(1, 1, 0);
    chk("R2 local with all-ones", line_tx_data, 1);
    chk("R1 local rcv sel", rcv_sel, 1);
    wr(1, 0, 1);
    chk("R3 remote over all-ones", line_tx_sel, 2);
    chk("R3 remote data", line_tx_data, rx_data);
    wr(0, 1, 1);
    chk("R4 reset pulse", reset_req, 1);
    settle();
    chk("R4 reset pulse ends", reset_req, 0);
    wr(0, 0, 0);

    // broken arming sequence
    wr(1, 1, 1);
    chk("R4 no reset on arm code", reset_req, 0);
    wr(0, 1, 0);
    wr(0, 0, 0);
    chk("R5 interrupted arming", nl_armed, 0);

    // proper arming
    wr(1, 1, 1);
    wr(0, 0, 0);
    chk("R5 armed", nl_armed, 1);

    // one error burst tolerated
    stream(5, 1, 69);
    send_bit(1'b0);
    stream(5, 71, 130);
    settle();
    chk("R11 tolerated burst", nl_active, 1);
    chk("R8 auto remote sel", line_tx_sel, 2);

    // local loopback suspends, line bits ignored
    wr(0, 1, 0);
    chk("R10 suspended", nl_active, 0);
    chk("R10 tx path", line_tx_sel, 0);
    stream(3, 1, 200);
    wr(0, 0, 0);
    chk("R10 resumes", nl_active, 1);

    // disable code
    stream(3, 1, 200);
    settle();
    chk("R9 disable clears", nl_active, 0);
    chk("R7 still armed", nl_armed, 1);

    // disarm and re-arm, then two bursts force a restart
    wr(0, 0, 1);
    settle();
    chk("R6 disarmed by remote", nl_armed, 0);
    wr(1, 1, 1);
    wr(0, 0, 0);
    stream(5, 1, 69);
    send_bit(1'b0);
    stream(5, 71, 79);
    send_bit(1'b0);
    stream(5, 81, 130);
    settle();
    chk("R11 restart delays qualify", nl_active, 0);
    stream(5, 131, 220);
    settle();
    chk("R8 qualifies after restart", nl_active, 1);

    wr(0, 0, 1);
    settle();
    chk("R9 remote clears auto", nl_active, 0);
    chk("R6 remote disarms", nl_armed, 0);
    wr(0, 0, 0);
    chk("R9 auto stays cleared", line_tx_sel, 0);

    // qualification and remote write in the same cycle
    wr(1, 1, 1);
    wr(0, 0, 0);
    begin
      int i = 1;
      while (m_run[0] != QB - 1 && i < 600) begin
        send_bit((i % 5) == 0);
        i++;
      end
      @(negedge clk);
      rx_bit_en = 1'b1; rx_data = ((i % 5) == 0);
      cfg_we = 1'b1; cfg_taos = 1'b0; cfg_lloop = 1'b0; cfg_rloop = 1'b1;
      @(negedge clk);
      rx_bit_en = 1'b0; cfg_we = 1'b0;
    end
    repeat (3) settle();
    chk("R9 clear wins auto", nl_active, 0);
    chk("R9 clear wins armed", nl_armed, 0);
    chk("R3 host remote kept", line_tx_sel, 2);
    wr(0, 0, 0);
    chk("R2 back to pass", line_tx_sel, 0);

    repeat (4) settle();
    finish_run();
  end

endmodule